// File: doc/BRIEF.md
# Interleaved Single-Error-Correcting Row Codec

This block sits between a word-wide client and a wide physical memory row. On a write it encodes a 137-bit data word into a 146-bit codeword: eight Hamming check bits plus one overall parity bit. It then spreads that codeword across a 1168-bit row that holds eight such words. Bit `j` of word `w` lands at row position `j*8 + w`, so the eight codewords are interleaved at a stride of eight. A physical cluster of up to eight adjacent bad cells therefore damages each word in at most one bit.

On a read the block gathers the selected word out of the row and computes the syndrome. It inverts a single flipped bit and returns the corrected data. It also flags whether a correction was made, or whether the syndrome cannot come from any single error. The write side is a read-modify-write helper: the storage supplies the current row, and the block returns the same row with only the addressed word's 146 cells replaced. An optional output register, on by default, adds one cycle to the read path.

Top module: `rowecc_codec`

## Requirements
- R1: `row_out` equals `row_in` except at positions `j*8 + wr_idx` for j = 0..145. Each of those positions holds codeword bit j of `wr_data`.
- R2: Codeword layout. Positions 1, 2, 4, 8, 16, 32, 64 and 128 carry Hamming checks. The check at position 2^i makes the XOR of all positions p in 1..145 with bit i of p set equal to zero. Data bit k fills the k-th remaining position among 3..145, in ascending order. Bit 0 makes the XOR of all 146 bits even.
- R3: When a row holds clean codewords, reading any word returns its data with both flags low.
- R4: A single flipped bit at any codeword position 1..145 is corrected. The exact data comes back with `rd_corrected` high and `rd_uncorrectable` low.
- R5: A flip of the parity bit alone (codeword bit 0) returns the exact data with `rd_corrected` high.
- R6: Some flips leave the syndrome inconsistent with a single error: the parity matches but the position syndrome is nonzero, or the parity fails and the position exceeds 145. Two flips in one word do this. The block then raises `rd_uncorrectable`, keeps `rd_corrected` low, and returns the received data bits unchanged.
- R7: If all eight cells of one group of eight adjacent row positions are flipped, every word is still read back correctly and reports a correction.
- R8: With `REG_OUT`=1, the read outputs reflect `rd_idx` and `row_in` one clock later. While `rst_n` is low at a clock edge, the outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_idx | input | 3 | Word slot to be written |
| wr_data | input | 137 | Data word to encode |
| row_in | input | 1168 | Current contents of the physical row |
| row_out | output | 1168 | Row with the addressed word replaced |
| rd_idx | input | 3 | Word slot to be read |
| rd_data | output | 137 | Corrected data word |
| rd_corrected | output | 1 | A single-bit correction was applied |
| rd_uncorrectable | output | 1 | The syndrome fits no single-bit error |

## Verification
The bench flips every one of the 146 codeword positions of one word in turn. A wrong data-to-position map or a wrong check mask would show up as wrong data at the affected positions. It flips bit 0 on its own, to catch a decoder that ignores the parity flip or corrupts data when that flip occurs. It flips whole groups of eight adjacent cells: an interleave with the wrong stride would put two errors into one word and report it uncorrectable. It writes each slot over a busy row, which catches a merge that disturbs a neighbour's cells. A double flip in one word must raise only the uncorrectable flag and return the raw bits; a decoder that tries to correct it would invert a third bit.

// File: rtl/rowecc_pkg.sv
`timescale 1ns/1ps
// Package: shared geometry of the row codec and compile-time helpers
// that derive codeword layout. Assumes 2**HAM_W > CW_W-1.
package rowecc_pkg;
    parameter int DATA_W = 137;
    parameter int HAM_W  = 8;
    parameter int NWORDS = 8;
    localparam int CW_W  = DATA_W + HAM_W + 1;
    localparam int ROW_W = CW_W * NWORDS;
    localparam int IDX_W = $clog2(NWORDS);

    // True for the parity slot (0) and the power-of-two check slots.
    function automatic bit is_chk_pos(input int p);
        return (p == 0) || ((p & (p - 1)) == 0);
    endfunction

    // Codeword position holding data bit k.
    function automatic int data_pos(input int k);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                if (cnt == k) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bit index stored at non-check codeword position p.
    function automatic int data_idx(input int p);
        int cnt;
        cnt = 0;
        for (int q = 1; q < p; q++) begin
            if (!is_chk_pos(q)) cnt++;
        end
        return cnt;
    endfunction

    // Positions covered by Hamming check i (bit i of the position set).
    function automatic logic [CW_W-1:0] cover_mask(input int i);
        logic [CW_W-1:0] m;
        m = '0;
        for (int p = 1; p < CW_W; p++) begin
            m[p] = ((p >> i) & 1) == 1;
        end
        return m;
    endfunction
endpackage

// File: rtl/rowecc_encode.sv
`timescale 1ns/1ps
// Encoder: places data bits into non-check slots, computes the Hamming
// checks over their coverage sets, then the overall even parity in slot 0.
// Purely combinational.
module rowecc_encode
    import rowecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   cw
);
    logic [CW_W-1:0]  placed;
    logic [HAM_W-1:0] chk;

    // Route each codeword slot to its data bit or to zero for check slots.
    for (genvar p = 0; p < CW_W; p++) begin : g_place
        if (is_chk_pos(p)) begin : g_hole
            assign placed[p] = 1'b0;
        end else begin : g_bit
            localparam int K = data_idx(p);
            assign placed[p] = data[K];
        end
    end

    // One Hamming check per syndrome bit.
    for (genvar i = 0; i < HAM_W; i++) begin : g_chk
        localparam logic [CW_W-1:0] M = cover_mask(i);
        assign chk[i] = ^(placed & M);
    end

    // Insert checks at power-of-two slots, then the overall parity.
    always_comb begin
        cw = placed;
        for (int i = 0; i < HAM_W; i++) begin
            cw[1 << i] = chk[i];
        end
        cw[0] = ^cw[CW_W-1:1];
    end
endmodule

// File: rtl/rowecc_scatter.sv
`timescale 1ns/1ps
// Scatter: writes one codeword into its interleaved slot of a row,
// leaving the other words' cells untouched. Bit j goes to j*NWORDS+idx.
module rowecc_scatter
    import rowecc_pkg::*;
(
    input  logic [ROW_W-1:0] row_in,
    input  logic [IDX_W-1:0] idx,
    input  logic [CW_W-1:0]  cw,
    output logic [ROW_W-1:0] row_out
);
    // Overlay the codeword at stride NWORDS, offset idx.
    always_comb begin
        row_out = row_in;
        for (int j = 0; j < CW_W; j++) begin
            row_out[j*NWORDS + int'(idx)] = cw[j];
        end
    end
endmodule

// File: rtl/rowecc_gather.sv
`timescale 1ns/1ps
// Gather: pulls the codeword of slot idx out of an interleaved row.
module rowecc_gather
    import rowecc_pkg::*;
(
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] idx,
    output logic [CW_W-1:0]  cw
);
    // One selector per codeword bit across its group of NWORDS cells.
    for (genvar j = 0; j < CW_W; j++) begin : g_sel
        logic [NWORDS-1:0] grp;
        assign grp   = row[j*NWORDS +: NWORDS];
        assign cw[j] = grp[idx];
    end
endmodule

// File: rtl/rowecc_decode.sv
`timescale 1ns/1ps
// Decoder: computes the position syndrome and overall parity, corrects
// one flipped bit when consistent with a single error, otherwise flags
// the word uncorrectable and passes received bits through.
module rowecc_decode
    import rowecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              corrected,
    output logic              uncorrectable
);
    localparam logic [CW_W-1:0] ONE = CW_W'(1);

    logic [HAM_W-1:0] syn;
    logic             par;
    logic [CW_W-1:0]  fixed;

    // Position syndrome bits.
    for (genvar i = 0; i < HAM_W; i++) begin : g_syn
        localparam logic [CW_W-1:0] M = cover_mask(i);
        assign syn[i] = ^(cw & M);
    end

    assign par = ^cw;

    // Classify the syndrome and apply at most one bit flip.
    always_comb begin
        fixed         = cw;
        corrected     = 1'b0;
        uncorrectable = 1'b0;
        if (par) begin
            if (int'(syn) < CW_W) begin
                fixed     = cw ^ (ONE << syn);
                corrected = 1'b1;
            end else begin
                uncorrectable = 1'b1;
            end
        end else if (syn != '0) begin
            uncorrectable = 1'b1;
        end
    end

    // Extract data bits from their slots.
    for (genvar k = 0; k < DATA_W; k++) begin : g_ext
        localparam int P = data_pos(k);
        assign data[k] = fixed[P];
    end
endmodule

// File: rtl/rowecc_codec.sv
`timescale 1ns/1ps
// Top: interleaved SEC row codec. Write side merges an encoded word into
// the supplied row; read side gathers, decodes and optionally registers.
// Assumes row_in is the current stored row for both paths.
module rowecc_codec
    import rowecc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  row_in,
    output logic [ROW_W-1:0]  row_out,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_corrected,
    output logic              rd_uncorrectable
);
    logic [CW_W-1:0]   wr_cw;
    logic [CW_W-1:0]   rd_cw;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr;
    logic              dec_unc;

    rowecc_encode  i_enc (.data(wr_data), .cw(wr_cw));
    rowecc_scatter i_sct (.row_in(row_in), .idx(wr_idx), .cw(wr_cw), .row_out(row_out));
    rowecc_gather  i_gth (.row(row_in), .idx(rd_idx), .cw(rd_cw));
    rowecc_decode  i_dec (.cw(rd_cw), .data(dec_data), .corrected(dec_corr),
                          .uncorrectable(dec_unc));

    if (REG_OUT) begin : g_reg
        // Register the read result, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data          <= '0;
                rd_corrected     <= 1'b0;
                rd_uncorrectable <= 1'b0;
            end else begin
                rd_data          <= dec_data;
                rd_corrected     <= dec_corr;
                rd_uncorrectable <= dec_unc;
            end
        end
    end else begin : g_comb
        assign rd_data          = dec_data;
        assign rd_corrected     = dec_corr;
        assign rd_uncorrectable = dec_unc;
    end
endmodule

// File: rtl/rowecc_codec_chk.sv
`timescale 1ns/1ps
// Checker: port-level properties of rowecc_codec, bound to every instance.
module rowecc_codec_chk
    import rowecc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [ROW_W-1:0]  row_in,
    input logic [ROW_W-1:0]  row_out,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_corrected,
    input logic              rd_uncorrectable
);
    // R8: reset clears the read outputs on the next edge.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !rd_corrected && !rd_uncorrectable));

    // R6: the two verdicts never coexist.
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corrected && rd_uncorrectable));

    // R8: steady read inputs give steady read outputs one cycle on.
    a_r8_steady_output: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(rd_idx) && $stable(row_in)) |=> $stable(rd_data));

    // R1: cells of non-addressed words pass through the merge.
    for (genvar w = 0; w < NWORDS; w++) begin : g_pass
        logic same;
        always_comb begin
            same = 1'b1;
            for (int j = 0; j < CW_W; j++) begin
                if (row_out[j*NWORDS + w] != row_in[j*NWORDS + w]) same = 1'b0;
            end
        end
        a_r1_other_words_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(wr_idx) != w) |-> same);
    end
endmodule

bind rowecc_codec rowecc_codec_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .row_in(row_in),
    .row_out(row_out), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable)
);

// File: tb/test_rowecc_codec.sv
`timescale 1ns/1ps
module test_rowecc_codec;
    import rowecc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ROW_W-1:0]  row_in = '0;
    logic [ROW_W-1:0]  row_out;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_corrected;
    logic              rd_uncorrectable;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] words [NWORDS];
    logic [ROW_W-1:0]  good_row;

    always #2 clk = ~clk;

    rowecc_codec i_rowecc_codec (.*);

    // Reference encoder: checks chosen so XOR of set-bit positions is 0.
    function automatic logic [CW_W-1:0] ref_enc(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] c;
        int k;
        int s;
        c = '0;
        k = 0;
        s = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                if (d[k]) s = s ^ p;
                k++;
            end
        end
        for (int i = 0; i < HAM_W; i++) c[1 << i] = ((s >> i) & 1) == 1;
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction

    // Raw data bits of a codeword, no correction.
    function automatic logic [DATA_W-1:0] ref_raw(input logic [CW_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        k = 0;
        d = '0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [ROW_W-1:0] ref_put(input logic [ROW_W-1:0] r,
                                                 input int w,
                                                 input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] c;
        c = ref_enc(d);
        for (int j = 0; j < CW_W; j++) r[j*NWORDS + w] = c[j];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] mk_word(input int seed);
        logic [159:0] t;
        t = {5{32'(seed) * 32'h9E37_79B1 + 32'h1234_5677}};
        return t[DATA_W-1:0] ^ {t[100:0], 36'h0};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a read at the falling edge, sample at the next falling edge.
    task automatic do_read(input int w, input logic [ROW_W-1:0] r,
                           input logic [DATA_W-1:0] exp_d, input bit exp_c,
                           input bit exp_u, input string tag);
        @(negedge clk);
        rd_idx = IDX_W'(w);
        row_in = r;
        @(negedge clk);
        chk(rd_data == exp_d, {tag, " data"}, ROW_W'(rd_data), ROW_W'(exp_d));
        chk({rd_corrected, rd_uncorrectable} == {exp_c, exp_u}, {tag, " flags"},
            ROW_W'({rd_corrected, rd_uncorrectable}), ROW_W'({exp_c, exp_u}));
    endtask

    initial begin
        logic [ROW_W-1:0] r;
        logic [ROW_W-1:0] exp_row;
        logic [CW_W-1:0]  c;
        // Reset state (R8).
        repeat (3) @(negedge clk);
        chk(rd_data == '0 && !rd_corrected && !rd_uncorrectable, "R8 reset",
            ROW_W'({rd_data, rd_corrected, rd_uncorrectable}), '0);
        rst_n = 1'b1;

        // Build a busy background row, then write each slot (R1, R2).
        r = '0;
        for (int b = 0; b < ROW_W; b += 32) r[b +: 16] = 16'hA5C3 ^ 16'(b);
        for (int w = 0; w < NWORDS; w++) begin
            words[w] = mk_word(w + 3);
            @(negedge clk);
            wr_idx  = IDX_W'(w);
            wr_data = words[w];
            row_in  = r;
            #1;
            exp_row = ref_put(r, w, words[w]);
            chk(row_out == exp_row, "R1 R2 merge", row_out, exp_row);
            r = exp_row;
        end
        good_row = r;

        // Clean reads (R3) and read latency (R8).
        for (int w = 0; w < NWORDS; w++)
            do_read(w, good_row, words[w], 1'b0, 1'b0, "R3 clean");
        @(negedge clk);
        rd_idx = 3'd6;
        #1;
        chk(rd_data == words[7], "R8 latency hold", ROW_W'(rd_data), ROW_W'(words[7]));
        @(negedge clk);
        chk(rd_data == words[6], "R8 latency update", ROW_W'(rd_data), ROW_W'(words[6]));

        // Single error at every codeword position of word 5 (R4, R5).
        for (int j = 0; j < CW_W; j++) begin
            r = good_row;
            r[j*NWORDS + 5] = ~r[j*NWORDS + 5];
            do_read(5, r, words[5], 1'b1, 1'b0, (j == 0) ? "R5 parity flip" : "R4 single");
        end

        // Cluster of eight adjacent cells flipped (R7).
        for (int g = 0; g < CW_W; g += 29) begin
            r = good_row;
            r[g*NWORDS +: NWORDS] = ~r[g*NWORDS +: NWORDS];
            for (int w = 0; w < NWORDS; w++)
                do_read(w, r, words[w], 1'b1, 1'b0, "R7 cluster");
        end

        // Double flip in one word (R6).
        r = good_row;
        r[9*NWORDS + 2]  = ~r[9*NWORDS + 2];
        r[77*NWORDS + 2] = ~r[77*NWORDS + 2];
        c = ref_enc(words[2]);
        c[9]  = ~c[9];
        c[77] = ~c[77];
        do_read(2, r, ref_raw(c), 1'b0, 1'b1, "R6 double");
        do_read(3, r, words[3], 1'b0, 1'b0, "R6 neighbour clean");

        // Reset mid-run clears outputs (R8).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rd_data == '0 && !rd_corrected && !rd_uncorrectable, "R8 reset again",
            ROW_W'({rd_data, rd_corrected, rd_uncorrectable}), '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule